// File: doc/BRIEF.md
# MAC-State Power Sequencer

This block sequences power enables and clock gates for a duty-cycled radio node. One register holds the current link-layer state. A fixed table maps each state to the set of domains that must be live: transmitter, receiver, frequency synthesizer (PLL), MAC engine, active-clock power manager, memory controller clock, data RAM clock and host CPU. The link-layer logic asks for state changes. The sequencer accepts each legal change, drops each illegal one and latches an error flag for it.

A wake-up timer is advanced by a strobe from the 32.768 kHz domain, brought into the system clock domain. Each time it reaches its programmable period it raises a one-cycle interrupt and reloads itself, so the wake-up phase never drifts. While the node sleeps only this timer is active, and its interrupt forces the node into the receive state. The radio enables follow a safe order. The PLL comes up a programmable number of cycles before the transmitter or receiver is enabled, and it goes down only after both of them are off.

Top module: `pwr_seq_top`

## Requirements
- R1: After synchronous reset the state is Sleep (code 0), every enable and clock-gate output is 0, `wake_irq` is 0 and `req_err` is 0.
- R2: State codes are Sleep=0, Transmitting=1, Receiving=2, Network=3. A request is legal when it names a different state and is not Sleep to Network. A legal request shows on `state_o` one cycle after it is presented.
- R3: An illegal request leaves the state and all enables unchanged and sets `req_err`. `req_err` then stays 1 until reset.
- R4: One cycle after a state change, the outputs follow the table. `mac_en`, `pm_en`, `memc_clk_en` and `ram_clk_en` are 1 in every state except Sleep. `cpu_en` is 1 only in Network, and never while a radio enable is high.
- R5: `tx_en` is 1 only in Transmitting and `rx_en` only in Receiving, once settled. The two are never high together.
- R6: When the node enters Transmitting or Receiving with the PLL off, `pll_en` rises one cycle after the state change. The radio enable rises exactly LEAD+1 cycles after `pll_en`.
- R7: When the node leaves a radio state for Sleep or Network, the radio enable falls one cycle after the state change. `pll_en` falls one cycle after that.
- R8: On a direct swap between Transmitting and Receiving with the PLL settled, `pll_en` stays 1. The old radio enable falls one cycle after the state change, and the new one rises in the cycle after that.
- R9: With period P, `wake_irq` pulses for one cycle on every P-th `tick` and the counter reloads automatically. The period after reset is DEF_PERIOD (3277 by default).
- R10: `wake_irq` while in Sleep moves the state to Receiving on the next cycle. If a request arrives in that same cycle, the request is dropped and no error is raised. `wake_irq` in any other state leaves the state unchanged.
- R11: A period write takes effect at once. A write of 0 is treated as 1. If the count has already reached the new P-1, the next tick fires the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | State-change request strobe |
| req_state | input | 2 | Requested state code |
| tick | input | 1 | One-cycle strobe per 32.768 kHz period |
| period_wr | input | 1 | Load wake-up period |
| period_val | input | PW | New wake-up period in ticks |
| state_o | output | 2 | Current state code |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| pll_en | output | 1 | Synthesizer enable |
| mac_en | output | 1 | MAC engine enable |
| pm_en | output | 1 | Active-clock power manager enable |
| cpu_en | output | 1 | Host CPU enable |
| memc_clk_en | output | 1 | Memory controller clock gate |
| ram_clk_en | output | 1 | Data RAM clock gate (RAM keeps its data when 0) |
| wake_irq | output | 1 | Wake-up timer interrupt pulse |
| req_err | output | 1 | Sticky illegal-request flag |

## Verification
The bench builds the block with LEAD=3, PW=16 and the default period of 3277. The short lead makes the exact PLL-to-radio spacing easy to count. The default period stays in place, so a full wake-up interval of real length can be stepped tick by tick. Every one of the sixteen from/to request pairs is swept, and each is judged for legality, error flag and settled domain table. Periods 0 to 5 are swept over several reload cycles. A shortened period written mid-count, wake-up with a competing request, and wake-up outside Sleep complete the set.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_TX    = 2'd1,
    ST_RX    = 2'd2,
    ST_NET   = 2'd3
  } mac_state_e;

  function automatic logic move_ok(mac_state_e from, mac_state_e to);
    return (from != to) && !(from == ST_SLEEP && to == ST_NET);
  endfunction
endpackage

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int PW         = 16,
  parameter int DEF_PERIOD = 3277
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          period_wr,
  input  logic [PW-1:0] period_val,
  output logic          wake_irq
);
  localparam logic [PW-1:0] DEF_P = PW'(DEF_PERIOD);
  localparam logic [PW-1:0] ONE   = PW'(1);

  logic [PW-1:0] per_q;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] per_m1;

  assign per_m1 = per_q - ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q    <= DEF_P;
      cnt_q    <= '0;
      wake_irq <= 1'b0;
    end else begin
      wake_irq <= 1'b0;
      if (period_wr)
        per_q <= (period_val == '0) ? ONE : period_val;
      if (tick) begin
        if (cnt_q >= per_m1) begin
          cnt_q    <= '0;
          wake_irq <= 1'b1;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end
    end
  end

  // R9: an interrupt always coincides with a freshly reloaded count
  p_reload_r9: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> (cnt_q == '0));

  // R11: the period register never holds zero
  p_per_nonzero_r11: assert property (@(posedge clk) disable iff (rst)
    per_q != '0);
endmodule

// File: rtl/pwr_mac_fsm.sv
module pwr_mac_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_state,
  input  logic       wake_irq,
  output mac_state_e st,
  output logic       req_err
);
  mac_state_e req_s;
  assign req_s = mac_state_e'(req_state);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_SLEEP;
      req_err <= 1'b0;
    end else if (st == ST_SLEEP && wake_irq) begin
      st <= ST_RX;
    end else if (req_valid) begin
      if (move_ok(st, req_s)) st <= req_s;
      else                    req_err <= 1'b1;
    end
  end

  // R10: timer wake from sleep lands in receive
  p_wake_rx_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLEEP && wake_irq) |=> (st == ST_RX));

  // R3: error flag is sticky
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    req_err |=> req_err);

  // R2: sleep never jumps straight to network processing
  p_no_net_jump_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SLEEP) |=> (st != ST_NET));
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int LEAD = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  mac_state_e st,
  output logic       tx_en,
  output logic       rx_en,
  output logic       pll_en,
  output logic       mac_en,
  output logic       pm_en,
  output logic       cpu_en,
  output logic       memc_clk_en,
  output logic       ram_clk_en
);
  localparam int LW = (LEAD < 1) ? 1 : $clog2(LEAD + 1);
  localparam logic [LW-1:0] LEAD_C = LW'(LEAD);

  logic [1:0]    want;
  logic [1:0]    radio;
  logic [LW-1:0] lc_q;
  logic          settled;

  assign want[0] = (st == ST_TX);
  assign want[1] = (st == ST_RX);
  assign settled = pll_en && (lc_q == LEAD_C);

  generate
    for (genvar i = 0; i < 2; i++) begin : g_radio
      logic r_q;
      always_ff @(posedge clk) begin
        if (rst)                            r_q <= 1'b0;
        else if (!want[i])                  r_q <= 1'b0;
        else if (settled && !radio[1 - i])  r_q <= 1'b1;
      end
      assign radio[i] = r_q;

      // R6: a radio enable only rises after the PLL lead has elapsed
      p_lead_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q) |-> ($past(pll_en) && $past(lc_q) == LEAD_C && pll_en));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                pll_en <= 1'b0;
    else if (want != 2'b00) pll_en <= 1'b1;
    else if (radio == 2'b00) pll_en <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !pll_en)      lc_q <= '0;
    else if (lc_q != LEAD_C) lc_q <= lc_q + LW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mac_en      <= 1'b0;
      pm_en       <= 1'b0;
      cpu_en      <= 1'b0;
      memc_clk_en <= 1'b0;
      ram_clk_en  <= 1'b0;
    end else begin
      mac_en      <= (st != ST_SLEEP);
      pm_en       <= (st != ST_SLEEP);
      cpu_en      <= (st == ST_NET);
      memc_clk_en <= (st != ST_SLEEP);
      ram_clk_en  <= (st != ST_SLEEP);
    end
  end

  assign tx_en = radio[0];
  assign rx_en = radio[1];

  // R5: transmitter and receiver never live together
  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(tx_en && rx_en));

  // R7: PLL drops only after both radios have been off
  p_pll_off_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_en) |-> (radio == 2'b00 && $past(radio) == 2'b00));

  // R4: host CPU never runs alongside a radio
  p_cpu_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_en |-> (radio == 2'b00));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int LEAD       = 8,
  parameter int PW         = 16,
  parameter int DEF_PERIOD = 3277
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_state,
  input  logic          tick,
  input  logic          period_wr,
  input  logic [PW-1:0] period_val,
  output logic [1:0]    state_o,
  output logic          tx_en,
  output logic          rx_en,
  output logic          pll_en,
  output logic          mac_en,
  output logic          pm_en,
  output logic          cpu_en,
  output logic          memc_clk_en,
  output logic          ram_clk_en,
  output logic          wake_irq,
  output logic          req_err
);
  mac_state_e st;

  pwr_wake_timer #(.PW(PW), .DEF_PERIOD(DEF_PERIOD)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .period_wr(period_wr),
    .period_val(period_val), .wake_irq(wake_irq)
  );

  pwr_mac_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_state(req_state),
    .wake_irq(wake_irq), .st(st), .req_err(req_err)
  );

  pwr_domain_ctrl #(.LEAD(LEAD)) u_dom (
    .clk(clk), .rst(rst), .st(st), .tx_en(tx_en), .rx_en(rx_en),
    .pll_en(pll_en), .mac_en(mac_en), .pm_en(pm_en), .cpu_en(cpu_en),
    .memc_clk_en(memc_clk_en), .ram_clk_en(ram_clk_en)
  );

  assign state_o = st;
endmodule

// File: tb/sim_pwr_seq_top.sv
`timescale 1ns/1ps
module sim_pwr_seq_top;
  localparam int LEAD = 3;
  localparam int PW   = 16;
  localparam int DEFP = 3277;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_state = 2'd0;
  logic tick = 1'b0;
  logic period_wr = 1'b0;
  logic [PW-1:0] period_val = '0;
  logic [1:0] state_o;
  logic tx_en, rx_en, pll_en, mac_en, pm_en, cpu_en, memc_clk_en, ram_clk_en;
  logic wake_irq, req_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwr_seq_top #(.LEAD(LEAD), .PW(PW), .DEF_PERIOD(DEFP)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_state(req_state),
    .tick(tick), .period_wr(period_wr), .period_val(period_val),
    .state_o(state_o), .tx_en(tx_en), .rx_en(rx_en), .pll_en(pll_en),
    .mac_en(mac_en), .pm_en(pm_en), .cpu_en(cpu_en),
    .memc_clk_en(memc_clk_en), .ram_clk_en(ram_clk_en),
    .wake_irq(wake_irq), .req_err(req_err)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
  endtask

  task automatic do_req(input int s);
    req_valid = 1'b1; req_state = 2'(s); step(); req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (LEAD + 6) step();
  endtask

  task automatic goto_state(input int s);
    case (s)
      1: do_req(1);
      2: do_req(2);
      3: begin do_req(2); do_req(3); end
      default: ;
    endcase
    settle();
  endtask

  task automatic set_period(input int p);
    period_wr = 1'b1; period_val = PW'(p); step(); period_wr = 1'b0;
  endtask

  task automatic check_domains(input string tag, input int s);
    chk({tag, " tx_en"},  int'(tx_en),  int'(s == 1));
    chk({tag, " rx_en"},  int'(rx_en),  int'(s == 2));
    chk({tag, " pll_en"}, int'(pll_en), int'(s == 1 || s == 2));
    chk({tag, " mac_en"}, int'(mac_en), int'(s != 0));
    chk({tag, " pm_en"},  int'(pm_en),  int'(s != 0));
    chk({tag, " cpu_en"}, int'(cpu_en), int'(s == 3));
    chk({tag, " memc_clk_en"}, int'(memc_clk_en), int'(s != 0));
    chk({tag, " ram_clk_en"},  int'(ram_clk_en),  int'(s != 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 state", int'(state_o), 0);
    chk("R1 irq", int'(wake_irq), 0);
    chk("R1 err", int'(req_err), 0);
    check_domains("R1", 0);

    // R2 R3 R4 R5: sweep of all request pairs
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        bit legal;
        legal = (f != t) && !(f == 0 && t == 3);
        do_reset();
        goto_state(f);
        do_req(t);
        chk($sformatf("R2 state %0d->%0d", f, t), int'(state_o), legal ? t : f);
        chk($sformatf("R3 err %0d->%0d", f, t), int'(req_err), int'(!legal));
        settle();
        check_domains($sformatf("R4 R5 %0d->%0d", f, t), legal ? t : f);
        if (!legal) begin
          step();
          chk("R3 err sticky", int'(req_err), 1);
        end
      end
    end

    // R6: PLL lead from sleep into receive
    do_reset();
    do_req(2);
    chk("R6 pll off at state change", int'(pll_en), 0);
    step();
    chk("R6 pll up", int'(pll_en), 1);
    chk("R4 mac with pll", int'(mac_en), 1);
    chk("R6 rx still off", int'(rx_en), 0);
    begin
      int n;
      n = 0;
      while (!rx_en && n < 20) begin
        step(); n++;
        chk("R6 pll held", int'(pll_en), 1);
      end
      chk("R6 lead cycles", n, LEAD + 1);
    end

    // R6 into transmit
    do_reset();
    do_req(1);
    step();
    repeat (LEAD) begin step(); chk("R6 tx waits", int'(tx_en), 0); end
    step();
    chk("R6 tx up", int'(tx_en), 1);

    // R7: leave receive for sleep
    do_reset();
    goto_state(2);
    do_req(0);
    step();
    chk("R7 rx down", int'(rx_en), 0);
    chk("R7 pll still up", int'(pll_en), 1);
    step();
    chk("R7 pll down", int'(pll_en), 0);

    // R7: leave transmit for network
    do_reset();
    goto_state(1);
    do_req(3);
    step();
    chk("R7 tx down", int'(tx_en), 0);
    chk("R7 pll up net", int'(pll_en), 1);
    chk("R4 cpu up", int'(cpu_en), 1);
    step();
    chk("R7 pll down net", int'(pll_en), 0);

    // R8: direct swap transmit -> receive
    do_reset();
    goto_state(1);
    do_req(2);
    step();
    chk("R8 tx down", int'(tx_en), 0);
    chk("R8 rx not yet", int'(rx_en), 0);
    chk("R8 pll kept", int'(pll_en), 1);
    step();
    chk("R8 rx up", int'(rx_en), 1);
    chk("R8 pll kept2", int'(pll_en), 1);

    // R9 default period
    do_reset();
    tick = 1'b1;
    for (int k = 1; k <= DEFP; k++) begin
      step();
      if (k >= DEFP - 2) chk($sformatf("R9 default tick %0d", k), int'(wake_irq), int'(k == DEFP));
      else if (wake_irq) chk($sformatf("R9 default early %0d", k), 1, 0);
    end
    tick = 1'b0;
    step();
    chk("R9 pulse width", int'(wake_irq), 0);

    // R9 R11 period sweep, zero treated as one
    for (int p = 0; p <= 5; p++) begin
      int pe;
      pe = (p == 0) ? 1 : p;
      do_reset();
      set_period(p);
      for (int k = 1; k <= 12; k++) begin
        tick = 1'b1; step(); tick = 1'b0;
        chk($sformatf("R9 R11 P=%0d tick %0d", p, k), int'(wake_irq), int'((k % pe) == 0));
        step();
        chk($sformatf("R9 P=%0d gap %0d", p, k), int'(wake_irq), 0);
      end
    end

    // R11 shortened period mid-count
    do_reset();
    set_period(10);
    for (int k = 0; k < 6; k++) begin
      tick = 1'b1; step(); tick = 1'b0;
      chk("R11 pre count", int'(wake_irq), 0);
    end
    set_period(3);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R11 immediate fire", int'(wake_irq), 1);
    for (int k = 1; k <= 3; k++) begin
      tick = 1'b1; step(); tick = 1'b0;
      chk("R11 after reload", int'(wake_irq), int'(k == 3));
    end

    // R10 wake with competing request
    do_reset();
    set_period(2);
    tick = 1'b1; step(); tick = 1'b0;
    tick = 1'b1; step(); tick = 1'b0;
    chk("R10 irq seen", int'(wake_irq), 1);
    chk("R10 still sleep", int'(state_o), 0);
    do_req(1);
    chk("R10 woke to rx", int'(state_o), 2);
    chk("R10 no err", int'(req_err), 0);
    settle();
    check_domains("R10 rx", 2);

    // R10 irq outside sleep
    do_req(1);
    settle();
    tick = 1'b1; step(); tick = 1'b0;
    tick = 1'b1; step(); tick = 1'b0;
    chk("R10 irq in tx", int'(wake_irq), 1);
    step();
    chk("R10 tx kept", int'(state_o), 1);
    check_domains("R10 tx", 1);

    finish_run();
  end
endmodule